// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits next to a memory shared by two ports and provides one mailbox word for each port at the top of the address space. Each port presents an address, a write strobe, a read strobe, write data and a busy input. It receives read data and an interrupt flag. A port sends a message by writing the mailbox that belongs to the other port. That raises the other port's interrupt. The receiving port clears its flag by reading its own mailbox.

A busy port is not allowed to change any interrupt state. Its write to the peer mailbox still stores the word but does not raise the peer's flag. Its read of its own mailbox returns the word but does not clear its own flag. All accesses are single-cycle strobes on one shared clock. The address and data widths are parameters.

Top module: `mbx_irq_pair`

## Requirements
- R1: While `rst_n` is low, both interrupt flags are 0 and both mailbox words are 0. This holds right away (asynchronous reset), and reads then return 0.
- R2: Port 0's mailbox is at address 2^ADDR_W-2 and port 1's mailbox is at 2^ADDR_W-1. An access to any other address changes no flag and no word, and a read of such an address returns 0.
- R3: A write by one port to the other port's mailbox, with the writer's busy low, sets the owner's flag at the next clock edge. A port that writes its own mailbox does not change its own flag.
- R4: When the owner reads its own mailbox with its busy low, its flag is cleared at the next clock edge.
- R5: A port that reads the other port's mailbox returns that word and leaves the other port's flag unchanged.
- R6: A peer-mailbox write made while the writer's busy is high does not set the owner's flag.
- R7: An owner read made while the owner's busy is high does not clear the owner's flag.
- R8: If a set (R3) and a clear (R4) of the same flag occur in the same cycle, the flag is 1 after the edge.
- R9: A mailbox write stores the write data unchanged, whatever the writer's busy level. Read data is combinational from the stored word for the address presented, so it shows the new word in the cycle after the write edge.
- R10: If both ports write the same mailbox in the same cycle, the data from the port that does not own that mailbox is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_addr | input | ADDR_W | Port 0 address |
| p0_wr | input | 1 | Port 0 write strobe |
| p0_rd | input | 1 | Port 0 read strobe |
| p0_busy | input | 1 | Port 0 busy; blocks port 0 interrupt effects |
| p0_wdata | input | DATA_W | Port 0 write data |
| p0_rdata | output | DATA_W | Port 0 read data |
| p0_irq | output | 1 | Port 0 interrupt flag, active high |
| p1_addr | input | ADDR_W | Port 1 address |
| p1_wr | input | 1 | Port 1 write strobe |
| p1_rd | input | 1 | Port 1 read strobe |
| p1_busy | input | 1 | Port 1 busy; blocks port 1 interrupt effects |
| p1_wdata | input | DATA_W | Port 1 write data |
| p1_rdata | output | DATA_W | Port 1 read data |
| p1_irq | output | 1 | Port 1 interrupt flag, active high |

## Verification
A wrong flag state shows up on `p0_irq` or `p1_irq` one edge after the strobe that should have set it, cleared it or left it alone. This is why every stimulus vector is followed by a check of both flags. A wrong mailbox word, or an address decoded to the wrong slot, shows up on the read data of either port as soon as that address is presented after the write edge. Reading through the non-owner port shows this without disturbing the flag. The same-cycle collisions (a set meeting a clear, and two writers on one word) are driven directly, because a wrong priority shows only in those cycles.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned MBX_PORTS = 2;

   // index of the port on the far side
   function automatic int unsigned peer_of(input int unsigned p);
      return MBX_PORTS - 1 - p;
   endfunction

   // distance of a port's mailbox below the top address
   function automatic int unsigned slot_from_top(input int unsigned p);
      return MBX_PORTS - 1 - p;
   endfunction
endpackage

// File: rtl/mbx_addr_match.sv
module mbx_addr_match #(
   parameter int unsigned         ADDR_W = 14,
   parameter logic [ADDR_W-1:0]   TARGET = '1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);
   assign hit_o = (addr_i == TARGET);
endmodule

// File: rtl/mbx_word.sv
module mbx_word #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              own_we_i,
   input  logic [DATA_W-1:0] own_d_i,
   input  logic              peer_we_i,
   input  logic [DATA_W-1:0] peer_d_i,
   output logic [DATA_W-1:0] q_o
);
   // the sender's message wins a same-cycle collision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q_o <= '0;
      else if (peer_we_i)  q_o <= peer_d_i;
      else if (own_we_i)   q_o <= own_d_i;
   end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_o <= 1'b0;
      else if (set_i)  flag_o <= 1'b1;
      else if (clr_i)  flag_o <= 1'b0;
   end
endmodule

// File: rtl/mbx_irq_pair.sv
module mbx_irq_pair
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] p0_addr,
   input  logic              p0_wr,
   input  logic              p0_rd,
   input  logic              p0_busy,
   input  logic [DATA_W-1:0] p0_wdata,
   output logic [DATA_W-1:0] p0_rdata,
   output logic              p0_irq,
   input  logic [ADDR_W-1:0] p1_addr,
   input  logic              p1_wr,
   input  logic              p1_rd,
   input  logic              p1_busy,
   input  logic [DATA_W-1:0] p1_wdata,
   output logic [DATA_W-1:0] p1_rdata,
   output logic              p1_irq
);
   localparam int unsigned       NP       = MBX_PORTS;
   localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("mbx_irq_pair: ADDR_W must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("mbx_irq_pair: DATA_W must be at least 1");
   end

   logic [ADDR_W-1:0] addr   [NP];
   logic [DATA_W-1:0] wdata  [NP];
   logic [DATA_W-1:0] rdata  [NP];
   logic [DATA_W-1:0] word_q [NP];
   logic [NP-1:0]     wr, rd, busy, irq;
   logic [NP*NP-1:0]  hit;     // hit[p*NP+m]: port p addresses mailbox m

   assign addr[0]  = p0_addr;
   assign addr[1]  = p1_addr;
   assign wdata[0] = p0_wdata;
   assign wdata[1] = p1_wdata;
   assign wr       = {p1_wr, p0_wr};
   assign rd       = {p1_rd, p0_rd};
   assign busy     = {p1_busy, p0_busy};
   assign p0_rdata = rdata[0];
   assign p1_rdata = rdata[1];
   assign p0_irq   = irq[0];
   assign p1_irq   = irq[1];

   // address decode: every port against every mailbox
   for (genvar p = 0; p < NP; p++) begin : g_port
      for (genvar m = 0; m < NP; m++) begin : g_slot
         mbx_addr_match #(
            .ADDR_W (ADDR_W),
            .TARGET (TOP_ADDR - ADDR_W'(slot_from_top(m)))
         ) u_match (
            .addr_i (addr[p]),
            .hit_o  (hit[p*NP+m])
         );
      end

      logic [DATA_W-1:0] sel;
      always_comb begin
         sel = '0;
         for (int m = 0; m < NP; m++) begin
            if (hit[p*NP+m]) sel = word_q[m];
         end
      end
      assign rdata[p] = sel;
   end

   // one stored word and one interrupt flag per mailbox owner
   for (genvar m = 0; m < NP; m++) begin : g_mbx
      localparam int unsigned PEER = peer_of(m);
      logic own_we, peer_we, set_req, clr_req;

      assign own_we  = wr[m]    & hit[m*NP+m];
      assign peer_we = wr[PEER] & hit[PEER*NP+m];
      assign set_req = peer_we  & ~busy[PEER];
      assign clr_req = rd[m] & hit[m*NP+m] & ~busy[m];

      mbx_word #(.DATA_W(DATA_W)) u_word (
         .clk       (clk),
         .rst_n     (rst_n),
         .own_we_i  (own_we),
         .own_d_i   (wdata[m]),
         .peer_we_i (peer_we),
         .peer_d_i  (wdata[PEER]),
         .q_o       (word_q[m])
      );

      mbx_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_req),
         .clr_i  (clr_req),
         .flag_o (irq[m])
      );
   end
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] p0_addr,
   input logic              p0_wr,
   input logic              p0_rd,
   input logic              p0_busy,
   input logic [DATA_W-1:0] p0_wdata,
   input logic [DATA_W-1:0] p0_rdata,
   input logic              p0_irq,
   input logic [ADDR_W-1:0] p1_addr,
   input logic              p1_wr,
   input logic              p1_rd,
   input logic              p1_busy,
   input logic [DATA_W-1:0] p1_wdata,
   input logic [DATA_W-1:0] p1_rdata,
   input logic              p1_irq
);
   localparam logic [ADDR_W-1:0] BOX1 = '1;
   localparam logic [ADDR_W-1:0] BOX0 = BOX1 - ADDR_W'(1);

   logic set0, set1, clr0, clr1;
   assign set0 = p1_wr && !p1_busy && (p1_addr == BOX0);
   assign set1 = p0_wr && !p0_busy && (p0_addr == BOX1);
   assign clr0 = p0_rd && !p0_busy && (p0_addr == BOX0);
   assign clr1 = p1_rd && !p1_busy && (p1_addr == BOX1);

   // R1
   irq_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!p0_irq && !p1_irq));

   // R2
   unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((p0_addr < BOX0) |-> (p0_rdata == '0)) and ((p1_addr < BOX0) |-> (p1_rdata == '0)));

   // R3
   irq0_set_chk: assert property (@(posedge clk) disable iff (!rst_n) set0 |=> p0_irq);

   // R3
   irq1_set_chk: assert property (@(posedge clk) disable iff (!rst_n) set1 |=> p1_irq);

   // R4
   irq0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr0 && !set0) |=> !p0_irq);

   // R4
   irq1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr1 && !set1) |=> !p1_irq);

   // R5 R6 R7: with no unblocked set or clear the flag holds
   irq0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set0 && !clr0) |=> $stable(p0_irq));

   // R5 R6 R7
   irq1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set1 && !clr1) |=> $stable(p1_irq));

   // R8
   set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((set0 && clr0) |=> p0_irq) and ((set1 && clr1) |=> p1_irq));

   // R9 R10: the sender's word is what the owner sees next
   peer_data0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p1_wr && p1_addr == BOX0) |=> (p0_addr != BOX0 || p0_rdata == $past(p1_wdata)));

   // R9 R10
   peer_data1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_wr && p0_addr == BOX1) |=> (p1_addr != BOX1 || p1_rdata == $past(p0_wdata)));
endmodule

bind mbx_irq_pair mbx_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .p0_addr(p0_addr), .p0_wr(p0_wr), .p0_rd(p0_rd), .p0_busy(p0_busy),
   .p0_wdata(p0_wdata), .p0_rdata(p0_rdata), .p0_irq(p0_irq),
   .p1_addr(p1_addr), .p1_wr(p1_wr), .p1_rd(p1_rd), .p1_busy(p1_busy),
   .p1_wdata(p1_wdata), .p1_rdata(p1_rdata), .p1_irq(p1_irq)
);

// File: tb/mbx_irq_pair_test.sv
module mbx_irq_pair_test;
   localparam int   PERIOD = 10;
   localparam int   AW = 14;
   localparam int   DW = 16;
   localparam logic [AW-1:0] M0 = 14'h3FFE;   // port 0 mailbox (R2)
   localparam logic [AW-1:0] M1 = 14'h3FFF;   // port 1 mailbox (R2)
   localparam logic [1:0] IDL = 2'd0, WR = 2'd1, RD = 2'd2;

   typedef struct packed {
      logic [AW-1:0] a0;
      logic [1:0]    op0;
      logic          b0;
      logic [AW-1:0] a1;
      logic [1:0]    op1;
      logic          b1;
      logic [DW-1:0] d;
      logic          e0;
      logic          e1;
      logic [3:0]    rq;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{14'h0,  IDL, 1'b0, M0,     WR,  1'b0, 16'hA5A5, 1'b1, 1'b0, 4'd3},  // R3
      '{14'h0,  IDL, 1'b0, M0,     RD,  1'b0, 16'h0,    1'b1, 1'b0, 4'd5},  // R5
      '{M0,     RD,  1'b1, 14'h0,  IDL, 1'b0, 16'h0,    1'b1, 1'b0, 4'd7},  // R7
      '{M0,     RD,  1'b0, 14'h0,  IDL, 1'b0, 16'h0,    1'b0, 1'b0, 4'd4},  // R4
      '{M1,     WR,  1'b1, 14'h0,  IDL, 1'b0, 16'h5555, 1'b0, 1'b0, 4'd6},  // R6
      '{M1,     WR,  1'b0, 14'h0,  IDL, 1'b0, 16'h1234, 1'b0, 1'b1, 4'd3},  // R3
      '{M1,     RD,  1'b0, 14'h0,  IDL, 1'b0, 16'h0,    1'b0, 1'b1, 4'd5},  // R5
      '{14'h0,  IDL, 1'b0, M1,     WR,  1'b0, 16'h7777, 1'b0, 1'b1, 4'd3},  // R3 own write
      '{14'h5,  WR,  1'b0, 14'h0,  IDL, 1'b0, 16'h9999, 1'b0, 1'b1, 4'd2},  // R2
      '{14'h0,  IDL, 1'b0, 14'h3FFD, RD, 1'b0, 16'h0,   1'b0, 1'b1, 4'd2},  // R2
      '{M1,     WR,  1'b0, M1,     RD,  1'b0, 16'hBEEF, 1'b0, 1'b1, 4'd8},  // R8
      '{14'h0,  IDL, 1'b0, M1,     RD,  1'b0, 16'h0,    1'b0, 1'b0, 4'd4},  // R4
      '{M0,     RD,  1'b0, M0,     WR,  1'b0, 16'h4242, 1'b1, 1'b0, 4'd8},  // R8
      '{M0,     RD,  1'b0, 14'h0,  IDL, 1'b0, 16'h0,    1'b0, 1'b0, 4'd4}   // R4
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] p0_addr = '0, p1_addr = '0;
   logic          p0_wr = 1'b0, p0_rd = 1'b0, p0_busy = 1'b0;
   logic          p1_wr = 1'b0, p1_rd = 1'b0, p1_busy = 1'b0;
   logic [DW-1:0] p0_wdata = '0, p1_wdata = '0;
   logic [DW-1:0] p0_rdata, p1_rdata;
   logic          p0_irq, p1_irq;
   int            checks = 0;
   int            fails  = 0;
   bit            done   = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   mbx_irq_pair #(.ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n),
      .p0_addr(p0_addr), .p0_wr(p0_wr), .p0_rd(p0_rd), .p0_busy(p0_busy),
      .p0_wdata(p0_wdata), .p0_rdata(p0_rdata), .p0_irq(p0_irq),
      .p1_addr(p1_addr), .p1_wr(p1_wr), .p1_rd(p1_rd), .p1_busy(p1_busy),
      .p1_wdata(p1_wdata), .p1_rdata(p1_rdata), .p1_irq(p1_irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle_all();
      p0_wr = 1'b0; p0_rd = 1'b0; p0_busy = 1'b0;
      p1_wr = 1'b0; p1_rd = 1'b0; p1_busy = 1'b0;
   endtask

   task automatic apply(input vec_t v);
      p0_addr = v.a0; p0_wr = (v.op0 == WR); p0_rd = (v.op0 == RD); p0_busy = v.b0;
      p1_addr = v.a1; p1_wr = (v.op1 == WR); p1_rd = (v.op1 == RD); p1_busy = v.b1;
      p0_wdata = v.d; p1_wdata = v.d;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      p0_addr = M0; p1_addr = M1;
      #1;
      check("R1 p0_irq in reset", 32'(p0_irq), 32'd0);
      check("R1 p1_irq in reset", 32'(p1_irq), 32'd0);
      check("R1 box0 in reset", 32'(p0_rdata), 32'd0);
      check("R1 box1 in reset", 32'(p1_rdata), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk: one strobe cycle, then both flags after the edge
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         apply(VECS[i]);
         @(negedge clk);
         idle_all();
         check($sformatf("R%0d vec%0d p0_irq", VECS[i].rq, i), 32'(p0_irq), 32'(VECS[i].e0));
         check($sformatf("R%0d vec%0d p1_irq", VECS[i].rq, i), 32'(p1_irq), 32'(VECS[i].e1));
      end

      // R9: message stored as written, visible from both ports
      @(negedge clk);
      p0_addr = M1; p0_wr = 1'b1; p0_wdata = 16'hC3C3;
      @(negedge clk);
      idle_all();
      p1_addr = M1;
      #1;
      check("R9 owner reads box1", 32'(p1_rdata), 32'h0000C3C3);
      check("R9 sender reads box1", 32'(p0_rdata), 32'h0000C3C3);
      check("R3 p1_irq after write", 32'(p1_irq), 32'd1);

      // R2: unmapped address reads zero
      p0_addr = 14'h0010;
      #1;
      check("R2 unmapped read", 32'(p0_rdata), 32'd0);

      // R6 R9: busy write stores data but raises no flag
      @(negedge clk);
      p1_addr = M0; p1_wr = 1'b1; p1_busy = 1'b1; p1_wdata = 16'h0F0F;
      @(negedge clk);
      idle_all();
      p0_addr = M0;
      #1;
      check("R9 busy write stored", 32'(p0_rdata), 32'h00000F0F);
      check("R6 busy write no irq", 32'(p0_irq), 32'd0);

      // R10: both ports write box0 in one cycle; port 1 (sender) wins
      @(negedge clk);
      p0_addr = M0; p0_wr = 1'b1; p0_wdata = 16'h1111;
      p1_addr = M0; p1_wr = 1'b1; p1_wdata = 16'h2222;
      @(negedge clk);
      idle_all();
      #1;
      check("R10 collision data", 32'(p0_rdata), 32'h00002222);
      check("R3 collision sets p0_irq", 32'(p0_irq), 32'd1);

      // R1: asynchronous reset mid-run
      #2;
      rst_n = 1'b0;
      #1;
      check("R1 async p0_irq", 32'(p0_irq), 32'd0);
      check("R1 async p1_irq", 32'(p1_irq), 32'd0);
      check("R1 async box0", 32'(p0_rdata), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule